// File: doc/BRIEF.md
# Two-Domain Mixed-Edge Scan Register Array

This block is a small array of scan-inserted flip-flops. The cells belong to two clock domains, and the second domain contains both rising-edge and falling-edge cells. In functional operation each cell is a one-bit pipeline stage. Cell `k` loads bit `k` of `data_in` and drives bit `k` of `data_out`. The first domain runs on `clk1`, the second on `clk2`, and each domain's clock passes through its own glitch-free gate with a functional enable.

For manufacturing test, all cells are stitched into a single serial path from `scan_in` to `scan_out`. The chain runs through the first-domain cells, then a lockup latch at the domain boundary, then the second domain's rising-edge cells, and finally its falling-edge cells. While `test_mode` is high, three overrides apply. Both domains are clocked by `test_clk` through a clock multiplexer. The clock gates are forced open. The asynchronous reset is masked, so a stray reset cannot disturb shifting.

Each cell works in one of three modes, decoded from `test_mode` and `scan_enable`:
- FUNC (`test_mode`=0): loads functional data.
- SHIFT (`test_mode`=1, `scan_enable`=1): loads its chain predecessor.
- CAPTURE (`test_mode`=1, `scan_enable`=0): loads functional data on the test clock.

The mode changes as follows:
- FUNC→SHIFT or FUNC→CAPTURE when `test_mode` rises.
- SHIFT↔CAPTURE whenever `scan_enable` toggles within a test session.
- Any mode→FUNC when `test_mode` falls.

Top module: `mixed_edge_scan_array`

## Requirements
- R1: With `test_mode`=0, a low `rst_n` asynchronously clears every cell, so `data_out` and `scan_out` read 0.
- R2: With `test_mode`=0, cell `k` loads `data_in[k]` regardless of `scan_enable`:
  - cells `[A_RISE-1:0]` on a rising `clk1`;
  - the next `B_RISE` cells on a rising `clk2`;
  - the top `B_FALL` cells on the following falling `clk2`.
- R3: With `test_mode`=0 and a domain's enable (`func_en1` for `clk1`, `func_en2` for `clk2`) low, that domain's cells hold their values through clock pulses.
- R4: With `test_mode`=1, every cell is clocked whatever the functional enables are.
- R5: With `test_mode`=1, `clk1` and `clk2` have no effect, and only `test_clk` moves the cells.
- R6: With `test_mode`=1, a low `rst_n` leaves all cell contents unchanged.
- R7: The chain order is `scan_in` → cell 0 → … → cell `L-1` → `scan_out` (`scan_out` = `data_out[L-1]`, `L` = `A_RISE+B_RISE+B_FALL`).
  - Shift a pattern in most significant bit first over `L` rising edges.
  - In the high phase after the last rising edge, `data_out` equals the pattern.
- R8: The falling-edge cells occupy the last `B_FALL` chain positions.
  - A bit presented to `scan_in` for rising edge `n` reaches `scan_out` at the falling edge after rising edge `n+L-2`.
  - That bit is readable in the high phase after rising edge `n+L-1`, and in no other sampled phase.
- R9: The lockup latch between cell `A_RISE-1` and cell `A_RISE` is transparent while the first domain's clock is low.
  - On each shift edge, cell `A_RISE` receives the value cell `A_RISE-1` held before that edge.
  - No bit is lost or doubled at the crossing.
- R10: A capture cycle loads `data_in` into all cells: `scan_enable` is low over one falling edge and the next rising edge, so falling cells capture on the falling edge and rising cells on the rising edge.
  - Shifting then presents the captured bits at `scan_out`, bit `L-1` first and one lower bit per falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk1 | input | 1 | Functional clock of the first domain |
| clk2 | input | 1 | Functional clock of the second domain |
| test_clk | input | 1 | Test clock that replaces both functional clocks in test mode |
| test_mode | input | 1 | High for a whole test session; selects the test clock and masks reset and gating |
| scan_enable | input | 1 | In test mode, 1 shifts and 0 captures |
| scan_in | input | 1 | Serial chain input |
| rst_n | input | 1 | Asynchronous active-low reset; masked in test mode |
| func_en1 | input | 1 | Functional clock enable of the first domain |
| func_en2 | input | 1 | Functional clock enable of the second domain |
| data_in | input | A_RISE+B_RISE+B_FALL | Functional data, one bit per cell |
| data_out | output | A_RISE+B_RISE+B_FALL | Cell contents, one bit per cell |
| scan_out | output | 1 | Serial chain output, equal to the last cell |

## Verification
A cell stuck in the wrong mode, or a crossing without its latch, shows up at `scan_out` within `L` shift edges. A missing latch appears as a doubled or dropped bit at chain position `A_RISE`. A rising cell placed after a falling cell shifts the walking one by a half cycle, so it arrives one sampled phase early or late. Errors in clock selection, gating or reset masking show on `data_out` after a single clock pulse or reset pulse, because the cell contents either change when they must hold or hold when they must change.

// File: rtl/scan_arr_pkg.sv
package scan_arr_pkg;

    typedef enum logic [1:0] {
        MODE_FUNC    = 2'd0,
        MODE_SHIFT   = 2'd1,
        MODE_CAPTURE = 2'd2
    } cell_mode_e;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } cell_edge_e;

    function automatic cell_mode_e mode_of(input logic test_on, input logic shift_on);
        cell_mode_e m;
        unique case ({test_on, shift_on})
            2'b11:   m = MODE_SHIFT;
            2'b10:   m = MODE_CAPTURE;
            default: m = MODE_FUNC;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/scan_arr_clk_unit.sv
module scan_arr_clk_unit (
    input  logic test_clk,
    input  logic func_clk,
    input  logic test_mode,
    input  logic func_en,
    input  logic rst_n,
    output logic gclk
);
    logic clk_sel;
    logic gate_open;

    // test clock replaces the functional clock for the whole session
    always_comb begin
        clk_sel = test_mode ? test_clk : func_clk;
    end

    // enable captured only while the clock is low: no partial pulses
    always_latch begin
        if (!clk_sel) begin
            gate_open = func_en | test_mode;
        end
    end

    assign gclk = clk_sel & gate_open;

    assert_gate_forced_R4: assert property (
        @(posedge clk_sel) disable iff (!rst_n)
        test_mode |-> gate_open
    );

    assert_gate_shut_R3: assert property (
        @(posedge clk_sel) disable iff (!rst_n)
        (!func_en && !test_mode) |-> !gate_open
    );

endmodule

// File: rtl/scan_arr_lockup.sv
module scan_arr_lockup (
    input  logic hold_clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    // open on the low phase of the launching clock, closed while it is high
    always_latch begin
        if (!rst_n) begin
            q = 1'b0;
        end else if (!hold_clk) begin
            q = d;
        end
    end

    assert_lockup_open_R9: assert property (
        @(posedge hold_clk) disable iff (!rst_n)
        q == d
    );

endmodule

// File: rtl/scan_arr_cell.sv
module scan_arr_cell
    import scan_arr_pkg::*;
#(
    parameter cell_edge_e EDGE = EDGE_RISE
) (
    input  logic       clk,
    input  logic       rst_n,
    input  cell_mode_e mode,
    input  logic       func_d,
    input  logic       scan_d,
    output logic       q
);
    logic d_sel;

    always_comb begin
        unique case (mode)
            MODE_SHIFT:   d_sel = scan_d;
            MODE_CAPTURE: d_sel = func_d;
            MODE_FUNC:    d_sel = func_d;
            default:      d_sel = func_d;
        endcase
    end

    generate
        if (EDGE == EDGE_RISE) begin : g_rise
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= 1'b0;
                end else begin
                    q <= d_sel;
                end
            end

            assert_shift_take_R7: assert property (
                @(posedge clk) disable iff (!rst_n)
                (mode == MODE_SHIFT) |=> (q == $past(scan_d))
            );

            assert_capture_take_R10: assert property (
                @(posedge clk) disable iff (!rst_n)
                (mode == MODE_CAPTURE) |=> (q == $past(func_d))
            );
        end else begin : g_fall
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= 1'b0;
                end else begin
                    q <= d_sel;
                end
            end

            assert_shift_take_R7: assert property (
                @(negedge clk) disable iff (!rst_n)
                (mode == MODE_SHIFT) |=> (q == $past(scan_d))
            );

            assert_capture_take_R10: assert property (
                @(negedge clk) disable iff (!rst_n)
                (mode == MODE_CAPTURE) |=> (q == $past(func_d))
            );
        end
    endgenerate

endmodule

// File: rtl/mixed_edge_scan_array.sv
module mixed_edge_scan_array
    import scan_arr_pkg::*;
#(
    parameter int unsigned A_RISE = 4,
    parameter int unsigned B_RISE = 3,
    parameter int unsigned B_FALL = 2
) (
    input  logic                             clk1,
    input  logic                             clk2,
    input  logic                             test_clk,
    input  logic                             test_mode,
    input  logic                             scan_enable,
    input  logic                             scan_in,
    input  logic                             rst_n,
    input  logic                             func_en1,
    input  logic                             func_en2,
    input  logic [A_RISE+B_RISE+B_FALL-1:0]  data_in,
    output logic [A_RISE+B_RISE+B_FALL-1:0]  data_out,
    output logic                             scan_out
);
    localparam int unsigned CHAIN_LEN  = A_RISE + B_RISE + B_FALL;
    localparam int unsigned CROSS_IDX  = A_RISE;
    localparam int unsigned FALL_START = A_RISE + B_RISE;
    localparam int unsigned NUM_DOM    = 2;

    logic                 rst_eff;
    cell_mode_e           mode;
    logic [NUM_DOM-1:0]   func_clk;
    logic [NUM_DOM-1:0]   func_en;
    logic [NUM_DOM-1:0]   dom_clk;
    logic [CHAIN_LEN-1:0] cell_q;
    logic [CHAIN_LEN-1:0] cell_si;
    logic                 lock_q;

    // reset masked for the whole test session
    always_comb begin
        rst_eff = rst_n | test_mode;
        mode    = mode_of(test_mode, scan_enable);
    end

    assign func_clk = {clk2, clk1};
    assign func_en  = {func_en2, func_en1};

    generate
        for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
            scan_arr_clk_unit u_clk (
                .test_clk  (test_clk),
                .func_clk  (func_clk[d]),
                .test_mode (test_mode),
                .func_en   (func_en[d]),
                .rst_n     (rst_eff),
                .gclk      (dom_clk[d])
            );
        end
    endgenerate

    scan_arr_lockup u_lock (
        .hold_clk (dom_clk[0]),
        .rst_n    (rst_eff),
        .d        (cell_q[CROSS_IDX-1]),
        .q        (lock_q)
    );

    generate
        for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
            if (i == 0) begin : g_head
                assign cell_si[i] = scan_in;
            end else if (i == CROSS_IDX) begin : g_cross
                assign cell_si[i] = lock_q;
            end else begin : g_link
                assign cell_si[i] = cell_q[i-1];
            end

            if (i < CROSS_IDX) begin : g_dom_a
                scan_arr_cell #(.EDGE(EDGE_RISE)) u_cell (
                    .clk    (dom_clk[0]),
                    .rst_n  (rst_eff),
                    .mode   (mode),
                    .func_d (data_in[i]),
                    .scan_d (cell_si[i]),
                    .q      (cell_q[i])
                );
            end else if (i < FALL_START) begin : g_dom_b_rise
                scan_arr_cell #(.EDGE(EDGE_RISE)) u_cell (
                    .clk    (dom_clk[1]),
                    .rst_n  (rst_eff),
                    .mode   (mode),
                    .func_d (data_in[i]),
                    .scan_d (cell_si[i]),
                    .q      (cell_q[i])
                );
            end else begin : g_dom_b_fall
                scan_arr_cell #(.EDGE(EDGE_FALL)) u_cell (
                    .clk    (dom_clk[1]),
                    .rst_n  (rst_eff),
                    .mode   (mode),
                    .func_d (data_in[i]),
                    .scan_d (cell_si[i]),
                    .q      (cell_q[i])
                );
            end
        end
    endgenerate

    assign data_out = cell_q;
    assign scan_out = cell_q[CHAIN_LEN-1];

    // the crossing must neither lose nor duplicate a bit
    assert_cross_hold_R9: assert property (
        @(posedge dom_clk[1]) disable iff (!rst_eff)
        (mode == MODE_SHIFT) |=> (cell_q[CROSS_IDX] == $past(cell_q[CROSS_IDX-1]))
    );

    // falling tail picks up the last rising cell half a cycle later
    assert_tail_half_R8: assert property (
        @(negedge dom_clk[1]) disable iff (!rst_eff)
        (mode == MODE_SHIFT) |=> (cell_q[FALL_START] == $past(cell_q[FALL_START-1]))
    );

endmodule

// File: tb/sim_mixed_edge_scan_array.sv
module sim_mixed_edge_scan_array;
    localparam int unsigned A_RISE = 4;
    localparam int unsigned B_RISE = 3;
    localparam int unsigned B_FALL = 2;
    localparam int unsigned LEN    = A_RISE + B_RISE + B_FALL;
    localparam int unsigned FALL_START = A_RISE + B_RISE;
    localparam logic [15:0] MASK   = 16'((1 << LEN) - 1);
    localparam int NVEC = 6;
    localparam logic [15:0] VEC [NVEC] = '{16'h01A5, 16'h0000, 16'h01FF,
                                          16'h0155, 16'h00AA, 16'h0133};

    logic osc = 1'b0;
    logic tck_run = 1'b1;
    logic test_clk;
    logic clk1, clk2, test_mode, scan_enable, scan_in, rst_n, func_en1, func_en2;
    logic [LEN-1:0] data_in;
    logic [LEN-1:0] data_out;
    logic scan_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 osc = ~osc;          // 125 MHz
    assign test_clk = osc & tck_run;

    mixed_edge_scan_array #(.A_RISE(A_RISE), .B_RISE(B_RISE), .B_FALL(B_FALL)) u0 (
        .clk1(clk1), .clk2(clk2), .test_clk(test_clk), .test_mode(test_mode),
        .scan_enable(scan_enable), .scan_in(scan_in), .rst_n(rst_n),
        .func_en1(func_en1), .func_en2(func_en2), .data_in(data_in),
        .data_out(data_out), .scan_out(scan_out)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // to the high phase, 2 ns after a rising edge of the test clock
    task automatic tick();
        @(posedge osc);
        #2;
    endtask

    task automatic pulse1();
        #1 clk1 = 1'b1;
        #2 clk1 = 1'b0;
        #2;
    endtask

    task automatic pulse2();
        #1 clk2 = 1'b1;
        #2 clk2 = 1'b0;
        #2;
    endtask

    task automatic shift_in(input logic [15:0] p);
        for (int j = 0; j < int'(LEN); j++) begin
            scan_in = p[LEN-1-j];
            tick();
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] p, c, e;
        clk1 = 0; clk2 = 0; test_mode = 0; scan_enable = 1; scan_in = 0;
        rst_n = 0; func_en1 = 1; func_en2 = 1; data_in = '0;
        #3;
        check("R1 reset state data_out", 16'(data_out), 16'h0000);
        check("R1 reset state scan_out", 16'(scan_out), 16'h0000);
        #5 rst_n = 1;

        // functional loading, scan_enable high must be ignored (R2)
        data_in = 9'h1A5;
        pulse1();
        check("R2 clk1 loads low cells", 16'(data_out), 16'h0005);
        #1 clk2 = 1'b1;
        #1 check("R2 rising clk2 loads middle cells", 16'(data_out), 16'h0025);
        clk2 = 1'b0;
        #1 check("R2 falling clk2 loads top cells", 16'(data_out), 16'h01A5);
        #2;

        // gating holds a domain (R3)
        func_en2 = 0;
        data_in = 9'h05A;
        pulse1();
        pulse2();
        check("R3 domain-2 gated holds", 16'(data_out), 16'h01AA);
        func_en1 = 0; func_en2 = 1;
        data_in = 9'h0F3;
        pulse1();
        pulse2();
        check("R3 domain-1 gated holds", 16'(data_out), 16'h00FA);

        rst_n = 0;
        #1 check("R1 async clear", 16'(data_out), 16'h0000);
        check("R1 async clear scan_out", 16'(scan_out), 16'h0000);
        #1 rst_n = 1;

        // enter test session with both enables low (R4)
        func_en1 = 0; func_en2 = 0;
        @(negedge osc);
        #1 test_mode = 1; scan_enable = 1;
        tick();

        for (int i = 0; i < NVEC; i++) begin
            p = VEC[i] & MASK;
            shift_in(p);
            check("R7 shifted pattern", 16'(data_out), p);
            check("R9 crossing pair", 16'(data_out[A_RISE:A_RISE-1]), 16'(p[A_RISE -: 2]));
            check("R4 scan_out with enables low", 16'(scan_out), 16'(p[LEN-1]));
            c = (p ^ 16'h0155) & MASK;
            data_in = c[LEN-1:0];
            scan_enable = 0;
            tick();
            check("R10 captured data", 16'(data_out), c);
            scan_enable = 1;
            scan_in = 0;
            check("R10 first unload bit", 16'(scan_out), 16'(c[LEN-1]));
            for (int k = 1; k < int'(LEN); k++) begin
                tick();
                check("R10 unload bit", 16'(scan_out), 16'(c[LEN-1-k]));
            end
        end

        // walking one latency (R8)
        scan_in = 0;
        repeat (LEN) tick();
        scan_in = 1;
        tick();
        scan_in = 0;
        for (int k = 1; k <= int'(LEN); k++) begin
            tick();
            check("R8 latency", 16'(scan_out), 16'(k == int'(LEN) - 1));
        end

        // reset mask and clock mux in test mode (R6, R5)
        p = 16'h00B6 & MASK;
        shift_in(p);
        e = p;
        for (int cidx = FALL_START; cidx < int'(LEN); cidx++) e[cidx] = p[cidx-1];
        @(negedge osc);
        tck_run = 0;
        #1 check("R8 tail after one falling edge", 16'(data_out), e);
        rst_n = 0;
        #3 check("R6 reset masked", 16'(data_out), e);
        rst_n = 1;
        data_in = ~e[LEN-1:0];
        scan_enable = 0;
        pulse1();
        pulse2();
        check("R5 functional clocks ignored", 16'(data_out), e);
        scan_enable = 1;
        @(negedge osc);
        #1 tck_run = 1;
        tick();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule